// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Engine

This block serves host reads from a serial flash device. A host issues a read as an address plus a byte count from 1 to 4. The block then runs one complete SPI transaction in command mode and returns the bytes as a single response word. The transaction has these phases in order: chip select goes low, the read opcode is shifted out, then the address, then an optional run of dummy bytes for fast-read timing, and finally the data bytes are clocked in.

A 32-bit per-chip configuration word sets the transaction shape. It holds the opcode, the address width (3 or 4 bytes), the dummy-byte count and the command-mode field. The count is three bits wide, but its bits sit at two separate positions in the word. The serial side runs SPI mode 0. SCLK is derived from the system clock by an even divide ratio, `CLK_DIV`.

Top module: `spi_flash_rd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy` and `rsp_valid` are 0.
- R2: A request is taken only when all of these hold: `busy` is low, `req_valid` is high, `cfg_word[1:0]` equals 0 (normal read mode), and `req_size` is in 1..4. Once taken, `busy` is high from the next cycle. A request that fails any of these conditions is ignored: `busy` stays low and `spi_cs_n` stays high.
- R3: The first byte on `spi_mosi` is the opcode from `cfg_word[23:16]`. Every byte is sent most significant bit first.
- R4: When `cfg_word[13]` is 1, the address phase sends `req_addr[31:0]`. When it is 0, the address phase sends `req_addr[23:0]`. The address goes out most significant byte first.
- R5: The dummy count N is `{cfg_word[14], cfg_word[7:6]}`. N bytes of 0xFF follow the address. When N is 0, no dummy byte is sent.
- R6: In the data phase the engine sends `req_size` bytes of 0x00 while it captures `spi_miso`. The SCLK rising-edge count of the whole transaction is 8 × (1 + address bytes + N + `req_size`).
- R7: The response is packed little-endian: the first data byte received goes to `rsp_data[7:0]`, the next to `[15:8]`, and so on. Byte lanes beyond `req_size` read 0.
- R8: SPI mode 0 timing applies. SCLK is low whenever chip select is inactive. Each SCLK high phase lasts `CLK_DIV/2` system cycles. MOSI changes only while SCLK is low. MISO is sampled on the rising edge.
- R9: After the last data byte, `spi_cs_n` goes high. Exactly `CLK_DIV` cycles later, `rsp_valid` pulses for one cycle, and `busy` falls in that same cycle.
- R10: A request presented while `busy` is high has no effect on the running transaction and produces no extra response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Flash byte address |
| req_size | input | 3 | Number of bytes to read, 1..4 |
| cfg_word | input | 32 | Per-chip read configuration word |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Packed read data, little-endian |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
`busy` is due one cycle after an accepted request. `rsp_valid` is due exactly `CLK_DIV` cycles after `spi_cs_n` rises. The bench samples on falling system-clock edges, counts completed rising edges to find the cycle of the `spi_cs_n` rise, and compares that count with the cycle in which the response strobe is seen.

The serial contents are checked in a different way. A flash model in the bench logs every MOSI byte and the length of each SCLK high phase. It supplies MISO bytes as a known function of the byte position. Those logs are compared against the opcode, address, dummy and data sequence that the bench computes for each request. The comparison runs only after the response strobe, so it does not depend on how the bytes are spaced in time.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int CFG_W     = 32;
    localparam int ADDR_W    = 32;
    localparam int RSP_BYTES = 4;
    localparam int RSP_W     = 8 * RSP_BYTES;
    localparam int SIZE_W    = 3;
    localparam int IDX_W     = 3;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [7:0] IDLE_BYTE = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       wide_addr;
        logic [2:0] dummies;
        logic [1:0] mode;
    } rd_cfg_t;

    function automatic rd_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        rd_cfg_t c;
        c.opcode    = w[23:16];
        c.wide_addr = w[13];
        c.dummies   = {w[14], w[7:6]};
        c.mode      = w[1:0];
        return c;
    endfunction

    function automatic logic [IDX_W-1:0] addr_len(input logic wide);
        return wide ? IDX_W'(4) : IDX_W'(3);
    endfunction

    // byte k of the address phase, most significant first
    function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a,
                                             input logic wide,
                                             input logic [IDX_W-1:0] k);
        logic [ADDR_W-1:0] s;
        logic [IDX_W-1:0]  pos;
        pos = addr_len(wide) - IDX_W'(1) - k;
        s   = a >> (8 * pos);
        return s[7:0];
    endfunction

endpackage

// File: rtl/spi_rd_clkgen.sv
module spi_rd_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    initial begin
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin
            $error("CLK_DIV must be even and at least 2");
        end
    end

endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    logic [7:0] sh;
    logic [2:0] bitn;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            done    <= 1'b0;
            sh      <= '0;
            bitn    <= '0;
            sclk    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx_byte;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R8
    // mosi_hold_high_chk
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    // R8
    // idle_low_chk
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk);

endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
    import spi_rd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              shift_done,
    input  logic [7:0]        rx_byte,
    output logic              start,
    output logic [7:0]        tx_byte,
    output logic              cs_n,
    output logic              busy,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_data
);
    localparam int GAP_W = $clog2(CLK_DIV + 1);

    phase_e            phase;
    rd_cfg_t           cfg_q;
    rd_cfg_t           cfg_in;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [IDX_W-1:0]  idx;
    logic [GAP_W-1:0]  gap_cnt;
    logic              take;
    logic [IDX_W-1:0]  alen;

    assign cfg_in = decode_cfg(cfg_word);
    assign take   = (phase == PH_IDLE) && req_valid && (cfg_in.mode == 2'b00)
                 && (req_size != '0) && (req_size <= SIZE_W'(RSP_BYTES));
    assign busy   = (phase != PH_IDLE);
    assign alen   = addr_len(cfg_q.wide_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            addr_q    <= '0;
            size_q    <= '0;
            idx       <= '0;
            gap_cnt   <= '0;
            start     <= 1'b0;
            tx_byte   <= '0;
            cs_n      <= 1'b1;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            start     <= 1'b0;
            rsp_valid <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (take) begin
                        cfg_q    <= cfg_in;
                        addr_q   <= req_addr;
                        size_q   <= req_size;
                        rsp_data <= '0;
                        cs_n     <= 1'b0;
                        phase    <= PH_CMD;
                        start    <= 1'b1;
                        tx_byte  <= cfg_in.opcode;
                    end
                end
                PH_CMD: begin
                    if (shift_done) begin
                        phase   <= PH_ADDR;
                        idx     <= '0;
                        start   <= 1'b1;
                        tx_byte <= addr_byte(addr_q, cfg_q.wide_addr, '0);
                    end
                end
                PH_ADDR: begin
                    if (shift_done) begin
                        start <= 1'b1;
                        if (idx != alen - IDX_W'(1)) begin
                            idx     <= idx + IDX_W'(1);
                            tx_byte <= addr_byte(addr_q, cfg_q.wide_addr, idx + IDX_W'(1));
                        end else if (cfg_q.dummies != '0) begin
                            phase   <= PH_DUMMY;
                            idx     <= '0;
                            tx_byte <= FILL_BYTE;
                        end else begin
                            phase   <= PH_DATA;
                            idx     <= '0;
                            tx_byte <= IDLE_BYTE;
                        end
                    end
                end
                PH_DUMMY: begin
                    if (shift_done) begin
                        start <= 1'b1;
                        if (idx != cfg_q.dummies - 3'd1) begin
                            idx     <= idx + IDX_W'(1);
                            tx_byte <= FILL_BYTE;
                        end else begin
                            phase   <= PH_DATA;
                            idx     <= '0;
                            tx_byte <= IDLE_BYTE;
                        end
                    end
                end
                PH_DATA: begin
                    if (shift_done) begin
                        rsp_data[8*idx +: 8] <= rx_byte;
                        if (idx != IDX_W'(size_q) - IDX_W'(1)) begin
                            idx     <= idx + IDX_W'(1);
                            start   <= 1'b1;
                            tx_byte <= IDLE_BYTE;
                        end else begin
                            phase   <= PH_GAP;
                            cs_n    <= 1'b1;
                            gap_cnt <= GAP_W'(CLK_DIV - 1);
                        end
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == '0) begin
                        phase     <= PH_IDLE;
                        rsp_valid <= 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt - GAP_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9
    // rsp_pulse_chk
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    // busy_end_chk
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);

    // R10
    // hold_req_chk
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(addr_q) && $stable(size_q)));

    // R5
    // dummy_fill_chk
    dummy_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (start && phase == PH_DUMMY) |-> (tx_byte == FILL_BYTE));

    // R2
    // sel_during_txn_chk
    sel_during_txn_chk: assert property (@(posedge clk) disable iff (rst)
        (phase inside {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA}) |-> !cs_n);

endmodule

// File: rtl/spi_flash_rd_engine.sv
module spi_flash_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [2:0]  req_size,
    input  logic [31:0] cfg_word,
    output logic        busy,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    logic       tick;
    logic       sh_active;
    logic       sh_done;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;

    spi_rd_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_active),
        .tick (tick)
    );

    spi_rd_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .tick    (tick),
        .miso    (spi_miso),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    spi_rd_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .cfg_word   (cfg_word),
        .shift_done (sh_done),
        .rx_byte    (sh_rx),
        .start      (sh_start),
        .tx_byte    (sh_tx),
        .cs_n       (spi_cs_n),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    // R8
    // sclk_deselect_chk
    sclk_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/spi_flash_rd_engine_tb.sv
module spi_flash_rd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] cfg_word = '0;
    logic        busy, rsp_valid, spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic [31:0] rsp_data;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;
    bit          finished = 1'b0;

    // flash model state
    logic [7:0]  miso_seed = 8'h00;
    logic [7:0]  mosi_log [64];
    int          nbytes   = 0;
    int          bitcnt   = 0;
    int          rises    = 0;
    int          bad_high = 0;
    int          rsp_seen = 0;
    logic [7:0]  shreg    = '0;
    time         rise_t   = 0;

    spi_flash_rd_engine #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .cfg_word(cfg_word), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rsp_valid) rsp_seen <= rsp_seen + 1;

    function automatic logic [7:0] flash_byte(input logic [7:0] seed, input int i);
        logic [7:0] k;
        k = 8'(i);
        return (seed + k * 8'h1D) ^ 8'h5C;
    endfunction

    always @(negedge spi_cs_n) begin
        bitcnt   = 0;
        nbytes   = 0;
        rises    = 0;
        bad_high = 0;
        spi_miso = flash_byte(miso_seed, 0) >> 7;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            shreg  = {shreg[6:0], spi_mosi};
            bitcnt = bitcnt + 1;
            rises  = rises + 1;
            rise_t = $time;
            if (bitcnt % 8 == 0 && nbytes < 64) begin
                mosi_log[nbytes] = shreg;
                nbytes = nbytes + 1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if ($time - rise_t != time'((DIV/2) * CLK_PERIOD)) bad_high = bad_high + 1;
            spi_miso = flash_byte(miso_seed, bitcnt / 8) >> (7 - (bitcnt % 8));
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // one full read; inject drives a stray request while busy (R10)
    task automatic run_txn(input logic [31:0] addr, input logic [2:0] size,
                           input logic [31:0] cfg, input bit inject);
        int alen, nd, hdr, total, t_rise, prev_cs, base_rsp, waited;
        logic [31:0] exp_data;
        bit ok;
        alen = cfg[13] ? 4 : 3;
        nd   = {cfg[14], cfg[7:6]};
        hdr  = 1 + alen + nd;
        total = hdr + size;
        miso_seed = 8'($urandom);
        base_rsp = rsp_seen;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = size; cfg_word = cfg;
        @(negedge clk);
        req_valid = 1'b0;
        // R2: busy one cycle after acceptance
        chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        t_rise = 0; prev_cs = spi_cs_n; waited = 0;
        while (!rsp_valid && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (inject && waited == 20) begin
                req_valid = 1'b1; req_addr = ~addr; req_size = 3'd1;
                cfg_word = cfg ^ 32'h00FF_2000;
            end else if (inject && waited == 21) begin
                req_valid = 1'b0; cfg_word = cfg;
            end
            if (prev_cs == 0 && spi_cs_n == 1) t_rise = int'(cyc);
            prev_cs = spi_cs_n;
        end
        // R9: response CLK_DIV cycles after chip select rises, busy low
        chk(int'(cyc) - t_rise == DIV, "R9 cs_n to rsp_valid cycles",
            32'(int'(cyc) - t_rise), 32'(DIV));
        chk(busy == 1'b0, "R9 busy low with rsp_valid", 32'(busy), 32'd0);
        exp_data = '0;
        for (int j = 0; j < int'(size); j++)
            exp_data[8*j +: 8] = flash_byte(miso_seed, hdr + j);
        // R7
        chk(rsp_data == exp_data, "R7 packed data", rsp_data, exp_data);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 rsp_valid single cycle", 32'(rsp_valid), 32'd0);
        // R6
        chk(nbytes == total, "R6 byte count", 32'(nbytes), 32'(total));
        chk(rises == 8 * total, "R6 sclk rising edges", 32'(rises), 32'(8 * total));
        // R3
        chk(mosi_log[0] == cfg[23:16], "R3 opcode", 32'(mosi_log[0]), 32'(cfg[23:16]));
        ok = 1'b1;
        for (int k = 0; k < alen; k++)
            if (mosi_log[1+k] != addr[8*(alen-1-k) +: 8]) ok = 1'b0;
        // R4
        chk(ok, "R4 address bytes", 32'(alen), 32'(alen));
        ok = 1'b1;
        for (int k = 0; k < nd; k++)
            if (mosi_log[1+alen+k] != 8'hFF) ok = 1'b0;
        // R5
        chk(ok, "R5 dummy bytes", 32'(nd), 32'(nd));
        ok = 1'b1;
        for (int k = 0; k < int'(size); k++)
            if (mosi_log[hdr+k] != 8'h00) ok = 1'b0;
        chk(ok, "R6 data phase mosi zero", 32'(size), 32'(size));
        // R8
        chk(bad_high == 0, "R8 sclk high width", 32'(bad_high), 32'd0);
        if (inject)
            // R10: only the one response, contents from first request
            chk(rsp_seen - base_rsp == 1, "R10 single response", 32'(rsp_seen - base_rsp), 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic bad_req(input logic [31:0] cfg, input logic [2:0] size);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1234_5678; req_size = size; cfg_word = cfg;
        @(negedge clk);
        req_valid = 1'b0;
        // R2: rejected request
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R2 rejected request",
            {30'd0, busy, spi_cs_n}, 32'd1);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R2 rejected request later",
            {30'd0, busy, spi_cs_n}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] c;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && busy == 1'b0 && rsp_valid == 1'b0,
            "R1 reset state", {28'd0, spi_cs_n, spi_sclk, busy, rsp_valid}, 32'h8);
        // directed: plain read, 3-byte address, no dummies
        run_txn(32'hA1B2_C3D4, 3'd1, 32'h0003_0000, 1'b0);
        // fast read, 4-byte address, max dummies
        run_txn(32'h0102_0304, 3'd4, 32'h000B_60C0, 1'b0);
        // dummy count only from high bit
        run_txn(32'h00FE_DCBA, 3'd2, 32'h000B_4000, 1'b0);
        // dummy count only from low bits, with stray request while busy
        run_txn(32'h5555_AAAA, 3'd3, 32'h000C_2040, 1'b1);
        // rejects: nonzero mode, size 0, size 5
        bad_req(32'h0003_0001, 3'd2);
        bad_req(32'h0003_0003, 3'd4);
        bad_req(32'h0003_0000, 3'd0);
        bad_req(32'h0003_0000, 3'd5);
        // constrained random
        for (int n = 0; n < 40; n++) begin
            c = $urandom;
            c[1:0] = 2'b00;
            run_txn($urandom, 3'(1 + ($urandom % 4)), c, (n % 7) == 3);
        end
        finish_run();
    end

endmodule